// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a bus-programmed watchdog. A 32-bit down-counter advances on clock cycles where the tick input is high and the counter is enabled. The first time the counter expires, the block raises an interrupt and reloads the counter. If software has not acknowledged that interrupt by the time the counter expires again, the block asserts a system reset request. The watchdog is refreshed by rewriting the reload value. Acknowledging the interrupt also restarts the count.

All configuration writes are blocked until a 32-bit key has been written to the lock register. Software writes the key, updates the block, and then writes any other value to the lock register to protect it again. Reads are never blocked. The bus has no wait states. Read data is combinational from the address.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the reload register (offset 0x000) and the count register (offset 0x004) read 0xFFFFFFFF. Control (offset 0x008) reads 0, and raw status (offset 0x010) reads 0. The lock register (offset 0xC00) reads 1, and `irq_o` and `sys_rst_o` are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and the lock register then reads 0. A write of any other value to 0xC00 locks the block, and it then reads 1. While the block is locked, writes to every other offset are ignored.
- R3: The count register decrements by one on each clock where `tick_i` is high and control bit 0 is set, provided the count is not zero. On all other clocks it holds, unless a reload or clear write occurs.
- R4: A tick that finds the count at zero with the raw flag clear sets the raw flag (bit 0 of offset 0x010). The same tick reloads the count from the reload register.
- R5: A tick that finds the count at zero with the raw flag set latches a reset request and reloads the count. From a fresh reload value L with continuous ticks, `sys_rst_o` (with control bit 1 set) rises after exactly 2×(L+1) ticks. The latched request stays set until a clear write or a reset.
- R6: An unlocked write to offset 0x000 stores the value and loads it into the count register on the same edge. A written 0 is stored as 1.
- R7: An unlocked write of any value to offset 0x00C clears the raw flag and the reset request, and reloads the count from the reload register.
- R8: Masked status (bit 0 of offset 0x014) and `irq_o` both equal the raw flag ANDed with control bit 0.
- R9: `sys_rst_o` equals the latched reset request ANDed with control bit 1. Writing 0 to control drops both `irq_o` and `sys_rst_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable pulse |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt, first-stage expiry |
| sys_rst_o | output | 1 | Reset request, second-stage expiry |

## Verification
The expiry path runs with a short reload value under an uninterrupted tick stream, then under a gapped tick stream. This separates the tick gating from the free-running clock and confirms the 2×(L+1) timing. Register writes are attempted while the block is locked and again after the key is written, which shows the lock actually gating each register. Clear writes and control changes are made at both stages, and a zero reload is written. These cases separate the masked view from the raw flag, the reset gate from the latched request, and the clamp from a plain store.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam logic [11:0] OFS_RELOAD = 12'h000;
   localparam logic [11:0] OFS_COUNT  = 12'h004;
   localparam logic [11:0] OFS_CTRL   = 12'h008;
   localparam logic [11:0] OFS_ACK    = 12'h00C;
   localparam logic [11:0] OFS_RAW    = 12'h010;
   localparam logic [11:0] OFS_MSK    = 12'h014;
   localparam logic [11:0] OFS_LOCK   = 12'hC00;

   typedef struct packed {
      logic rst_en;
      logic run_en;
   } ctrl_t;
endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg #(
   parameter int          DATA_W     = 32,
   parameter int          CNT_W      = 32,
   parameter logic [31:0] KEY        = 32'h1ACCE551,
   parameter bit          CLAMP_ZERO = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [11:0]         addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic                unlocked,
   output wdg_pkg::ctrl_t      ctrl,
   output logic [CNT_W-1:0]    reload_q,
   output logic                ld_wr,
   output logic [CNT_W-1:0]    ld_val,
   output logic                ack_wr
);
   import wdg_pkg::*;

   logic open_wr;

   assign open_wr = we && unlocked;
   assign ld_wr   = open_wr && (addr == OFS_RELOAD);
   assign ack_wr  = open_wr && (addr == OFS_ACK);

   generate
      if (CLAMP_ZERO) begin : g_clamp
         assign ld_val = (wdata[CNT_W-1:0] == '0) ? CNT_W'(1) : wdata[CNT_W-1:0];
      end else begin : g_plain
         assign ld_val = wdata[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         ctrl     <= '0;
         reload_q <= '1;
      end else begin
         if (we && addr == OFS_LOCK)
            unlocked <= (wdata[31:0] == KEY);
         if (open_wr && addr == OFS_CTRL)
            ctrl <= ctrl_t'(wdata[1:0]);
         if (ld_wr)
            reload_q <= ld_val;
      end
   end

   AST_LOCK_HOLDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && we && addr == OFS_RELOAD) |=> $stable(reload_q)); // R2
   AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && we && addr == OFS_CTRL) |=> $stable(ctrl)); // R2
   AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wr |=> (reload_q != '0)); // R6
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             ld_wr,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ack_wr,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             raw_q,
   output logic             fire_q
);
   logic step;
   logic at_zero;

   assign step    = tick && run_en;
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '1;
         raw_q  <= 1'b0;
         fire_q <= 1'b0;
      end else if (ld_wr) begin
         cnt_q <= ld_val;
      end else if (ack_wr) begin
         cnt_q  <= reload_q;
         raw_q  <= 1'b0;
         fire_q <= 1'b0;
      end else if (step) begin
         if (at_zero) begin
            cnt_q <= reload_q;
            if (raw_q) fire_q <= 1'b1;
            else       raw_q  <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_zero && !ld_wr && !ack_wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld_wr && !ack_wr) |=> $stable(cnt_q)); // R3
   AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_zero && !raw_q && !ld_wr && !ack_wr) |=> (raw_q && !fire_q)); // R4
   AST_FIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_q && !ack_wr) |=> fire_q); // R5
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !ld_wr) |=> (!raw_q && !fire_q)); // R7
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          CNT_W      = 32,
   parameter logic [31:0] KEY        = 32'h1ACCE551,
   parameter bit          CLAMP_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              sys_rst_o
);
   import wdg_pkg::*;

   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (ADDR_W != 12) begin : g_bad_addr
         $error("wdog_two_stage: ADDR_W must be 12");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("wdog_two_stage: DATA_W must be 32");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wdog_two_stage: CNT_W out of range");
      end
   endgenerate

   logic             unlocked;
   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload_q;
   logic             ld_wr;
   logic [CNT_W-1:0] ld_val;
   logic             ack_wr;
   logic [CNT_W-1:0] cnt_q;
   logic             raw_q;
   logic             fire_q;

   wdg_cfg #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY), .CLAMP_ZERO(CLAMP_ZERO)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .unlocked(unlocked), .ctrl(ctrl), .reload_q(reload_q),
      .ld_wr(ld_wr), .ld_val(ld_val), .ack_wr(ack_wr)
   );

   wdg_core #(.CNT_W(CNT_W)) i_core (
      .clk(clk), .rst_n(rst_n), .tick(tick_i), .run_en(ctrl.run_en),
      .ld_wr(ld_wr), .ld_val(ld_val), .ack_wr(ack_wr), .reload_q(reload_q),
      .cnt_q(cnt_q), .raw_q(raw_q), .fire_q(fire_q)
   );

   assign irq_o     = raw_q && ctrl.run_en;
   assign sys_rst_o = fire_q && ctrl.rst_en;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
         OFS_COUNT:  bus_rdata = {{PAD_W{1'b0}}, cnt_q};
         OFS_CTRL:   bus_rdata[1:0] = ctrl;
         OFS_RAW:    bus_rdata[0] = raw_q;
         OFS_MSK:    bus_rdata[0] = irq_o;
         OFS_LOCK:   bus_rdata[0] = !unlocked;
         default:    bus_rdata = '0;
      endcase
   end

   AST_CTRL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && unlocked && bus_addr == OFS_CTRL && bus_wdata[1:0] == 2'b00)
      |=> (!irq_o && !sys_rst_o)); // R9
   AST_RESET_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire_q) |-> $past(raw_q)); // R5
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        sys_rst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   longint m_reload = 64'hFFFFFFFF;
   longint m_cnt    = 64'hFFFFFFFF;
   int     m_ctrl   = 0;
   bit     m_raw    = 0;
   bit     m_fire   = 0;
   bit     m_open   = 0;

   always #10 clk = ~clk;

   wdog_two_stage i_wdog_two_stage (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         longint nv;
         if (bus_we && bus_addr == 12'hC00) m_open = (bus_wdata == 32'h1ACCE551);
         else if (bus_we && m_open && bus_addr == 12'h000) begin
            nv = (bus_wdata == 0) ? 1 : longint'(bus_wdata);
            m_reload = nv; m_cnt = nv;
         end else if (bus_we && m_open && bus_addr == 12'h00C) begin
            m_raw = 0; m_fire = 0; m_cnt = m_reload;
         end else begin
            if (tick_i && m_ctrl[0]) begin
               if (m_cnt == 0) begin
                  m_cnt = m_reload;
                  if (m_raw) m_fire = 1; else m_raw = 1;
               end else m_cnt = m_cnt - 1;
            end
            if (bus_we && m_open && bus_addr == 12'h008) m_ctrl = int'(bus_wdata[1:0]);
         end
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every-cycle comparison of the outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R8", irq_o, m_raw && m_ctrl[0]);
         check("R9", sys_rst_o, m_fire && m_ctrl[1]);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string req, input longint exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(12'h000, "R1", 64'hFFFFFFFF);
      rd(12'h004, "R1", 64'hFFFFFFFF);
      rd(12'h008, "R1", 0);
      rd(12'h010, "R1", 0);
      rd(12'hC00, "R1", 1);
      check("R1", irq_o, 0);
      check("R1", sys_rst_o, 0);
      // R2 locked writes ignored
      wr(12'h000, 32'd7);
      wr(12'h008, 32'd3);
      rd(12'h000, "R2", 64'hFFFFFFFF);
      rd(12'h008, "R2", 0);
      wr(12'hC00, 32'h1ACCE551);
      rd(12'hC00, "R2", 0);
      // R6 reload write loads the count
      wr(12'h000, 32'd5);
      rd(12'h004, "R6", 5);
      wr(12'h008, 32'd3);
      // R3 decrement with continuous ticks
      ticks(3);
      rd(12'h004, "R3", 2);
      // R3 no tick, no change
      repeat (4) @(negedge clk);
      rd(12'h004, "R3", 2);
      // R4 first expiry after L+1 ticks total
      ticks(3);
      rd(12'h010, "R4", 1);
      rd(12'h004, "R4", 5);
      check("R4", sys_rst_o, 0);
      // R5 reset at exactly 2*(L+1) ticks
      ticks(5);
      check("R5", sys_rst_o, 0);
      ticks(1);
      check("R5", sys_rst_o, 1);
      ticks(4);
      check("R5", sys_rst_o, 1);
      // R9 control bit 1 off gates the request
      wr(12'h008, 32'd1);
      check("R9", sys_rst_o, 0);
      check("R9", irq_o, 1);
      // R8 masked view with control bit 0 off
      wr(12'h008, 32'd2);
      rd(12'h014, "R8", 0);
      rd(12'h010, "R8", 1);
      check("R9", sys_rst_o, 1);
      wr(12'h008, 32'd0);
      check("R9", sys_rst_o, 0);
      check("R9", irq_o, 0);
      // R7 clear write
      wr(12'h008, 32'd3);
      wr(12'h00C, 32'hDEAD0000);
      rd(12'h010, "R7", 0);
      check("R7", sys_rst_o, 0);
      rd(12'h004, "R7", 5);
      // R3 gapped tick stream
      for (int i = 0; i < 4; i++) begin
         ticks(1);
         repeat (2) @(negedge clk);
      end
      rd(12'h004, "R3", 1);
      // R6 zero reload stored as one
      wr(12'h000, 32'd0);
      rd(12'h000, "R6", 1);
      rd(12'h004, "R6", 1);
      // R2 relock and ignored write
      wr(12'hC00, 32'h12345678);
      rd(12'hC00, "R2", 1);
      wr(12'h000, 32'd9);
      rd(12'h000, "R2", 1);
      wr(12'h00C, 32'd1);
      ticks(4);
      rd(12'h010, "R2", 1);
      check("R5", sys_rst_o, 1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule